// File: doc/BRIEF.md
# Panel controller byte-bus register block

This block is the serial-side register front end of a display panel controller. A byte-level bus engine hands it the bytes it receives and asks it for bytes to send. On writes, the first byte of a transaction selects a register and each later byte is written to the selected register, with the write pointer stepping by one per byte. The block decodes the stored values into panel controls: panel power, output drive mode, colour inversion, colour bit realignment, horizontal and vertical scan flip, and red/blue swap.

Reads use a separate read pointer, which is loaded by writing register 0x40. Each pair of read bytes returns the current read address and then the contents of that address. The read pointer then advances by one. Two factory pages, each opened by writing a key byte to its own unlock register, hold scratch bytes for panel tuning. While a page is open it takes the place of the normal registers in its address window. A write to the trigger register latches a checksum over the configuration registers and raises a done flag.

Top module: `lcdc_i2c_regs`

## Requirements
- R1: A byte with `wr_first`=1 loads the write pointer. Each byte with `wr_first`=0 is written to the register at the pointer, and the pointer then steps by one.
- R2: Writing register 0x40 sets the read pointer and restarts the read sequence. Reads alternate between two bytes: first the pointer value, then the data at that pointer. After each data byte the pointer steps by one, wrapping from 0xFF to 0x00. `rd_data` and `rd_valid` appear in the cycle after `rd_en`.
- R3: Writes are masked per register, and masked-off bits read as 0. The masks are 0x11 for 0x01 (display), 0x03 for 0x10 (interface) and 0x7F for 0x11 (image).
- R4: In register 0x01, bit4 drives `panel_on`. The value 0x11 sets `out_undriven`, and the value 0x01 sets `fast_burnin`.
- R5: Register 0x10 bit0 drives `col_invert` and bit1 drives `col_shift`. Register 0x11 bit0 drives `hflip`, bit1 drives `rb_swap` and bit2 drives `vflip`.
- R6: Register 0xFF reads {MFR_ID, REV_ID} (0xC7 by default), and register 0x62 reads 0x01. Unmapped addresses read 0x00. Writes to read-only or unmapped addresses have no effect.
- R7: Writing 0xAA to 0xAF opens factory page A. Writing any other value to 0xAF closes it. Register 0xAF reads 0x01 while the page is open and 0x00 while it is closed.
- R8: While page A is open, addresses 0x10..0x1F read and write factory storage, the normal registers and their outputs do not change, and 0x40 still works. After the page is closed the normal view returns, and the factory bytes are kept.
- R9: Register 0x03 opens page B (0x04..0x0F) with the same key rule. While page B is closed, its addresses read 0x00.
- R10: When bit0 of 0x54 (mask 0x01) goes from 0 to 1, register 0x55 becomes 0x01 and stays there. On the same rise, register 0x56 captures rotl1(disp^iface)^img. A write that does not make this rise leaves 0x56 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | A received byte is present |
| wr_first | input | 1 | The byte is the register pointer |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Request for one transmit byte |
| rd_data | output | 8 | Transmit byte |
| rd_valid | output | 1 | `rd_data` updated this cycle |
| panel_on | output | 1 | Panel displaying |
| out_undriven | output | 1 | Panel on, output held undriven |
| fast_burnin | output | 1 | Panel off, fast discharge |
| col_invert | output | 1 | Invert colour data |
| col_shift | output | 1 | Realign 6-bit colour by 2 |
| hflip | output | 1 | Horizontal scan flip |
| rb_swap | output | 1 | Swap red and blue |
| vflip | output | 1 | Vertical scan flip |

## Verification
Directed sequences cover several cases:
- an all-ones write, which separates masking from plain storage;
- a burst write, which shows whether the pointer steps;
- a read starting at 0xFF, which exposes pointer wrap;
- shadowed writes with the factory page open, which show whether a page leaks into the normal registers or loses its contents when closed;
- a repeated write of 1 to the trigger register, which distinguishes edge capture from level capture.

Random writes use keys that are usually correct and random data. They are interleaved with paired reads from random start points, which exercises the interaction between the open page state, the masks and the read sequence.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  localparam int DW = 8;

  localparam logic [DW-1:0] A_DISP  = 8'h01;
  localparam logic [DW-1:0] A_IFACE = 8'h10;
  localparam logic [DW-1:0] A_IMG   = 8'h11;
  localparam logic [DW-1:0] A_RDPTR = 8'h40;
  localparam logic [DW-1:0] A_TRIG  = 8'h54;
  localparam logic [DW-1:0] A_CSTAT = 8'h55;
  localparam logic [DW-1:0] A_CVAL  = 8'h56;
  localparam logic [DW-1:0] A_READY = 8'h62;
  localparam logic [DW-1:0] A_ID    = 8'hFF;
  localparam logic [DW-1:0] A_KEY_A = 8'hAF;
  localparam logic [DW-1:0] A_KEY_B = 8'h03;

  localparam logic [DW-1:0] M_DISP  = 8'h11;
  localparam logic [DW-1:0] M_IFACE = 8'h03;
  localparam logic [DW-1:0] M_IMG   = 8'h7F;
  localparam logic [DW-1:0] M_TRIG  = 8'h01;

  localparam logic [DW-1:0] UNLOCK_KEY = 8'hAA;

  function automatic logic [DW-1:0] apply_mask(input logic [DW-1:0] d,
                                               input logic [DW-1:0] m);
    return d & m;
  endfunction

  // placeholder checksum: rotate-left-1 of (disp ^ iface), xor image cfg
  function automatic logic [DW-1:0] panel_sum(input logic [DW-1:0] disp,
                                              input logic [DW-1:0] iface,
                                              input logic [DW-1:0] img);
    logic [DW-1:0] x;
    x = disp ^ iface;
    return {x[DW-2:0], x[DW-1]} ^ img;
  endfunction
endpackage

// File: rtl/lcdc_host_port.sv
module lcdc_host_port
  import lcdc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_first,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [DW-1:0] rd_value,
  output logic          wr_strobe,
  output logic [DW-1:0] wr_addr,
  output logic [DW-1:0] wr_byte,
  output logic [DW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [DW-1:0] wptr, rptr;
  logic          data_phase;
  logic          ptr_load;

  assign wr_strobe = wr_en && !wr_first;
  assign wr_addr   = wptr;
  assign wr_byte   = wr_data;
  assign rd_addr   = rptr;
  assign ptr_load  = wr_strobe && (wptr == A_RDPTR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
    end else if (wr_en && wr_first) begin
      wptr <= wr_data;
    end else if (wr_strobe) begin
      wptr <= wptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr       <= '0;
      data_phase <= 1'b0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (ptr_load) begin
        rptr       <= wr_data;
        data_phase <= 1'b0;
      end else if (rd_en) begin
        rd_data    <= data_phase ? rd_value : rptr;
        data_phase <= !data_phase;
        if (data_phase) rptr <= rptr + 1'b1;
      end
    end
  end

  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> wptr == $past(wptr) + 8'd1); // R1
  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R2
  AST_RD_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ptr_load) |=> data_phase != $past(data_phase)); // R2
  AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && data_phase && !ptr_load) |=> rptr == $past(rptr) + 8'd1); // R2
  AST_RPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !data_phase && !ptr_load) |=> $stable(rptr)); // R2
endmodule

// File: rtl/lcdc_regfile.sv
module lcdc_regfile
  import lcdc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wr_addr,
  input  logic [DW-1:0] wr_byte,
  output logic [DW-1:0] disp,
  output logic [DW-1:0] iface,
  output logic [DW-1:0] img,
  output logic [DW-1:0] trig,
  output logic [DW-1:0] csum_done,
  output logic [DW-1:0] csum_val
);
  logic trig_rise;

  assign trig_rise = we && (wr_addr == A_TRIG) && wr_byte[0] && !trig[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp  <= '0;
      iface <= '0;
      img   <= '0;
      trig  <= '0;
    end else if (we) begin
      case (wr_addr)
        A_DISP:  disp  <= apply_mask(wr_byte, M_DISP);
        A_IFACE: iface <= apply_mask(wr_byte, M_IFACE);
        A_IMG:   img   <= apply_mask(wr_byte, M_IMG);
        A_TRIG:  trig  <= apply_mask(wr_byte, M_TRIG);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csum_done <= '0;
      csum_val  <= '0;
    end else if (trig_rise) begin
      csum_done <= 8'h01;
      csum_val  <= panel_sum(disp, iface, img);
    end
  end

  AST_CFG_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(disp) && $stable(iface) && $stable(img)); // R3
  AST_CSUM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    csum_done[0] |=> csum_done[0]); // R10
  AST_CSUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_rise |=> $stable(csum_val)); // R10
  AST_CSUM_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> csum_done == 8'h01); // R10
endmodule

// File: rtl/lcdc_factory_page.sv
module lcdc_factory_page
  import lcdc_pkg::*;
#(
  parameter logic [7:0] BASE     = 8'h10,
  parameter int         DEPTH    = 16,
  parameter logic [7:0] KEY_ADDR = 8'hAF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_strobe,
  input  logic [DW-1:0] wr_addr,
  input  logic [DW-1:0] wr_byte,
  input  logic [DW-1:0] rd_addr,
  output logic          unlocked,
  output logic          wr_hit,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data
);
  localparam int         IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [8:0] LIM = 9'(DEPTH);

  logic [8:0]    wofs, rofs;
  logic          w_in, r_in, key_wr;
  logic [IW-1:0] widx, ridx;
  logic [DW-1:0] mem [DEPTH];

  assign wofs   = {1'b0, wr_addr} - {1'b0, BASE};
  assign rofs   = {1'b0, rd_addr} - {1'b0, BASE};
  assign w_in   = !wofs[8] && (wofs < LIM);
  assign r_in   = !rofs[8] && (rofs < LIM);
  assign widx   = wofs[IW-1:0];
  assign ridx   = rofs[IW-1:0];
  assign key_wr = wr_strobe && (wr_addr == KEY_ADDR);
  assign wr_hit = wr_strobe && unlocked && w_in;
  assign rd_hit = unlocked && r_in;
  assign rd_data = rd_hit ? mem[ridx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_wr) unlocked <= (wr_byte == UNLOCK_KEY);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)                             mem[g] <= '0;
      else if (wr_hit && widx == IW'(g))      mem[g] <= wr_byte;
    end
  end

  AST_LOCK_ONLY_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(unlocked)); // R7
endmodule

// File: rtl/lcdc_i2c_regs.sv
module lcdc_i2c_regs
  import lcdc_pkg::*;
#(
  parameter logic [3:0] MFR_ID   = 4'hC,
  parameter logic [3:0] REV_ID   = 4'h7,
  parameter logic [7:0] FA_BASE  = 8'h10,
  parameter int         FA_DEPTH = 16,
  parameter logic [7:0] FB_BASE  = 8'h04,
  parameter int         FB_DEPTH = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_first,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       panel_on,
  output logic       out_undriven,
  output logic       fast_burnin,
  output logic       col_invert,
  output logic       col_shift,
  output logic       hflip,
  output logic       rb_swap,
  output logic       vflip
);
  localparam logic [DW-1:0] ID_BYTE = {MFR_ID, REV_ID};

  logic          wr_strobe, reg_we;
  logic [DW-1:0] wr_addr, wr_byte, rd_addr, rd_value;
  logic [DW-1:0] disp, iface, img, trig, csum_done, csum_val;
  logic          fa_unl, fa_wr_hit, fa_rd_hit;
  logic          fb_unl, fb_wr_hit, fb_rd_hit;
  logic [DW-1:0] fa_data, fb_data;

  lcdc_host_port u_port (
    .clk, .rst_n, .wr_en, .wr_first, .wr_data, .rd_en,
    .rd_value, .wr_strobe, .wr_addr, .wr_byte, .rd_addr, .rd_data, .rd_valid
  );

  lcdc_factory_page #(.BASE(FA_BASE), .DEPTH(FA_DEPTH), .KEY_ADDR(A_KEY_A)) u_page_a (
    .clk, .rst_n, .wr_strobe, .wr_addr, .wr_byte, .rd_addr,
    .unlocked(fa_unl), .wr_hit(fa_wr_hit), .rd_hit(fa_rd_hit), .rd_data(fa_data)
  );

  lcdc_factory_page #(.BASE(FB_BASE), .DEPTH(FB_DEPTH), .KEY_ADDR(A_KEY_B)) u_page_b (
    .clk, .rst_n, .wr_strobe, .wr_addr, .wr_byte, .rd_addr,
    .unlocked(fb_unl), .wr_hit(fb_wr_hit), .rd_hit(fb_rd_hit), .rd_data(fb_data)
  );

  assign reg_we = wr_strobe && !fa_wr_hit && !fb_wr_hit;

  lcdc_regfile u_regs (
    .clk, .rst_n, .we(reg_we), .wr_addr, .wr_byte,
    .disp, .iface, .img, .trig, .csum_done, .csum_val
  );

  always_comb begin
    rd_value = '0;
    if (fa_rd_hit)      rd_value = fa_data;
    else if (fb_rd_hit) rd_value = fb_data;
    else begin
      case (rd_addr)
        A_DISP:  rd_value = disp;
        A_IFACE: rd_value = iface;
        A_IMG:   rd_value = img;
        A_RDPTR: rd_value = rd_addr;
        A_TRIG:  rd_value = trig;
        A_CSTAT: rd_value = csum_done;
        A_CVAL:  rd_value = csum_val;
        A_READY: rd_value = 8'h01;
        A_KEY_A: rd_value = {7'b0, fa_unl};
        A_KEY_B: rd_value = {7'b0, fb_unl};
        A_ID:    rd_value = ID_BYTE;
        default: rd_value = '0;
      endcase
    end
  end

  assign panel_on     = disp[4];
  assign out_undriven = disp[4] && disp[0];
  assign fast_burnin  = !disp[4] && disp[0];
  assign col_invert   = iface[0];
  assign col_shift    = iface[1];
  assign hflip        = img[0];
  assign rb_swap      = img[1];
  assign vflip        = img[2];

  AST_SHADOW_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    fa_wr_hit |=> $stable(iface) && $stable(img)); // R8
  AST_SHADOW_KEEPS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_wr_hit || fb_wr_hit) |=> $stable(col_invert) && $stable(hflip) && $stable(vflip)); // R8
endmodule

// File: tb/tb_lcdc_i2c_regs.sv
module tb_lcdc_i2c_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_first = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rd_valid, panel_on, out_undriven, fast_burnin;
  logic       col_invert, col_shift, hflip, rb_swap, vflip;

  int n_tests = 0;
  int n_fail  = 0;

  // expected state
  logic [7:0] m_disp = 0, m_iface = 0, m_img = 0, m_trig = 0;
  logic [7:0] m_done = 0, m_val = 0, m_rdaddr = 0;
  logic       m_fa_unl = 0, m_fb_unl = 0;
  logic [7:0] m_fa [16];
  logic [7:0] m_fb [12];

  always #5 clk = !clk;

  lcdc_i2c_regs dut (
    .clk, .rst_n, .wr_en, .wr_first, .wr_data, .rd_en, .rd_data, .rd_valid,
    .panel_on, .out_undriven, .fast_burnin, .col_invert, .col_shift,
    .hflip, .rb_swap, .vflip
  );

  function automatic logic [7:0] exp_sum(input logic [7:0] d, input logic [7:0] f,
                                         input logic [7:0] i);
    logic [15:0] t;
    t = {d ^ f, d ^ f};
    return t[14:7] ^ i;
  endfunction

  function automatic logic in_a(input logic [7:0] a);
    return (a >= 8'h10) && (a <= 8'h1F);
  endfunction

  function automatic logic in_b(input logic [7:0] a);
    return (a >= 8'h04) && (a <= 8'h0F);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (m_fa_unl && in_a(a)) return m_fa[a - 8'h10];
    if (m_fb_unl && in_b(a)) return m_fb[a - 8'h04];
    case (a)
      8'h01: return m_disp;
      8'h10: return m_iface;
      8'h11: return m_img;
      8'h40: return m_rdaddr;
      8'h54: return m_trig;
      8'h55: return m_done;
      8'h56: return m_val;
      8'h62: return 8'h01;
      8'hAF: return {7'b0, m_fa_unl};
      8'h03: return {7'b0, m_fb_unl};
      8'hFF: return 8'hC7;
      default: return 8'h00;
    endcase
  endfunction

  task automatic mdl_write(input logic [7:0] a, input logic [7:0] d);
    if (m_fa_unl && in_a(a)) m_fa[a - 8'h10] = d;
    else if (m_fb_unl && in_b(a)) m_fb[a - 8'h04] = d;
    else begin
      case (a)
        8'h01: m_disp  = d & 8'h11;
        8'h10: m_iface = d & 8'h03;
        8'h11: m_img   = d & 8'h7F;
        8'h40: m_rdaddr = d;
        8'h54: begin
          if (d[0] && !m_trig[0]) begin
            m_done = 8'h01;
            m_val  = exp_sum(m_disp, m_iface, m_img);
          end
          m_trig = {7'b0, d[0]};
        end
        8'hAF: m_fa_unl = (d == 8'hAA);
        8'h03: m_fb_unl = (d == 8'hAA);
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic send(input logic first, input logic [7:0] b);
    wr_en = 1'b1; wr_first = first; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0; wr_first = 1'b0;
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    send(1'b1, a);
    send(1'b0, d);
    mdl_write(a, d);
  endtask

  task automatic read_byte(output logic [7:0] b);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    b = rd_data;
    chk("R2 rd_valid", {7'b0, rd_valid}, 8'h01);
  endtask

  task automatic read_pair(input string req);
    logic [7:0] b;
    read_byte(b);
    chk({req, " addr byte"}, b, m_rdaddr);
    read_byte(b);
    chk({req, " data byte"}, b, exp_rd(m_rdaddr));
    m_rdaddr = m_rdaddr + 8'd1;
  endtask

  task automatic read_at(input logic [7:0] a, input string req);
    write_reg(8'h40, a);
    read_pair(req);
  endtask

  task automatic chk_outs(input string req);
    chk({req, " R4 panel_on"},     {7'b0, panel_on},     {7'b0, m_disp[4]});
    chk({req, " R4 out_undriven"}, {7'b0, out_undriven}, {7'b0, m_disp == 8'h11});
    chk({req, " R4 fast_burnin"},  {7'b0, fast_burnin},  {7'b0, m_disp == 8'h01});
    chk({req, " R5 col_invert"},   {7'b0, col_invert},   {7'b0, m_iface[0]});
    chk({req, " R5 col_shift"},    {7'b0, col_shift},    {7'b0, m_iface[1]});
    chk({req, " R5 hflip"},        {7'b0, hflip},        {7'b0, m_img[0]});
    chk({req, " R5 rb_swap"},      {7'b0, rb_swap},      {7'b0, m_img[1]});
    chk({req, " R5 vflip"},        {7'b0, vflip},        {7'b0, m_img[2]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pick [16] = '{8'h01, 8'h10, 8'h11, 8'h13, 8'h1F, 8'h54, 8'h55, 8'h56,
                              8'h62, 8'hFF, 8'hAF, 8'h03, 8'h05, 8'h0F, 8'h20, 8'h00};
    logic [7:0] v;
    for (int i = 0; i < 16; i++) m_fa[i] = 8'h00;
    for (int i = 0; i < 12; i++) m_fb[i] = 8'h00;
    void'($urandom(32'd20250428));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R2 reset rd_valid", {7'b0, rd_valid}, 8'h00);
    chk_outs("reset");
    read_pair("R2 reset pointer");

    // masking and display decode
    write_reg(8'h01, 8'hFF);
    chk_outs("R3 disp all-ones");
    read_at(8'h01, "R3 disp mask");
    write_reg(8'h01, 8'h01);
    chk_outs("R4 fast burn-in");
    write_reg(8'h01, 8'h10);
    chk_outs("R4 on with colour");

    // burst write, pointer steps
    send(1'b1, 8'h10);
    send(1'b0, 8'hFF); mdl_write(8'h10, 8'hFF);
    send(1'b0, 8'hFF); mdl_write(8'h11, 8'hFF);
    chk_outs("R1 burst");
    read_at(8'h10, "R1 R3 iface");
    read_pair("R1 R3 img");

    // identity, ready, read-only and unmapped
    write_reg(8'hFF, 8'h00);
    write_reg(8'h62, 8'h00);
    write_reg(8'h20, 8'h55);
    read_at(8'hFF, "R6 id");
    read_at(8'h62, "R6 ready");
    read_at(8'h20, "R6 unmapped");

    // wrap from 0xFF
    write_reg(8'h40, 8'hFF);
    read_byte(v); chk("R2 wrap addr FF", v, 8'hFF);
    read_byte(v); chk("R2 wrap data FF", v, 8'hC7);
    read_byte(v); chk("R2 wrap addr 00", v, 8'h00);
    read_byte(v); chk("R2 wrap data 00", v, 8'h00);
    m_rdaddr = 8'h01;

    // factory page A shadows
    write_reg(8'hAF, 8'hAA);
    read_at(8'hAF, "R7 key reads open");
    write_reg(8'h10, 8'h5A);
    chk_outs("R8 shadow keeps pins");
    read_at(8'h10, "R8 shadow read");
    write_reg(8'hAF, 8'h00);
    read_at(8'h10, "R8 closed normal view");
    read_at(8'hAF, "R7 key reads closed");
    write_reg(8'hAF, 8'hAA);
    read_at(8'h10, "R8 content kept");
    write_reg(8'hAF, 8'h3C);

    // factory page B
    read_at(8'h05, "R9 closed reads zero");
    write_reg(8'h03, 8'hAA);
    write_reg(8'h05, 8'hE4);
    read_at(8'h05, "R9 open write");
    write_reg(8'h03, 8'h01);
    read_at(8'h05, "R9 closed again");

    // checksum
    read_at(8'h55, "R10 before trigger");
    write_reg(8'h54, 8'h01);
    read_at(8'h55, "R10 done");
    read_at(8'h56, "R10 value");
    write_reg(8'h10, 8'h01);
    write_reg(8'h54, 8'hFF);
    read_at(8'h56, "R10 level no recapture");
    write_reg(8'h54, 8'h00);
    write_reg(8'h54, 8'h01);
    read_at(8'h56, "R10 new rise");
    read_at(8'h54, "R10 trig mask");

    // random
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, d;
      a = pick[$urandom_range(15, 0)];
      d = 8'($urandom);
      if ((a == 8'hAF || a == 8'h03) && ($urandom_range(1, 0) == 1)) d = 8'hAA;
      write_reg(a, d);
      chk_outs("rand R3 R5");
      if (i % 4 == 0) begin
        if ($urandom_range(1, 0) == 1) write_reg(8'h40, pick[$urandom_range(15, 0)]);
        else write_reg(8'h40, 8'($urandom));
        for (int k = 0; k < 3; k++) read_pair("rand R2 R8 R9");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule